// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins and turns selected pin behaviour into latched events. Each pin has its own sense setting that chooses low-level, high-level, falling-edge, rising-edge or any-edge detection. Pins are brought into the clock domain before any comparison is made. Detected events stay latched until software clears them with a write-one-to-clear access.

An enable mask, changed through separate set and clear writes, decides which latched events reach the pin's dedicated interrupt output. Software reaches everything through a plain 32-bit register port. Writes take effect on the clock edge and reads are combinational from the current address.

Top module: `extint_sense_ctrl`

## Requirements
- R1: The parameter NUM_IN (1 to 32) sets the number of pins. Register bits at position NUM_IN and above always read 0.
- R2: Each pin passes through two flip-flops. The monitor register at byte offset 0x104 returns bit n as the level pin n had two clock edges earlier.
- R3: Pin n has a sense register at offset 0x180 + 4*n. Only bits [5:0] are stored, and bits [31:6] are ignored on write and read as 0. Bit 0 selects low level, bit 1 selects high level, bit 2 selects falling edge and bit 3 selects rising edge, so 0x0C detects both edges. Bits 4 and 5 have no effect on detection.
- R4: Bit n of the detect register at offset 0x100 becomes 1 when pin n shows its selected condition, and then stays 1 until it is cleared.
- R5: Writing 1 to a detect bit clears it, and writing 0 leaves it unchanged. If the condition holds in the same cycle as the clear, the bit stays 1, so a bit cleared while its level is still active does not drop.
- R6: A pin whose sense field is 0 never sets its detect bit.
- R7: Writing 1s to offset 0x08 turns on the matching enable bits and leaves the other enable bits unchanged. Offset 0x08 reads 0.
- R8: Writing 1s to offset 0x04 turns off the matching enable bits. Reading offset 0x04 returns the enable mask.
- R9: Offset 0x00 reads the detect bits ANDed with the enable bits.
- R10: Output irq_o[n] is 1 exactly when detect bit n and enable bit n are both 1.
- R11: After reset, all sense fields, enable bits and detect bits are 0. Any offset not listed above reads 0.
- R12: A pin edge sets its detect bit on the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pins_i | input | NUM_IN | Asynchronous external interrupt pins |
| irq_o | output | NUM_IN | Per-pin interrupt lines |

## Verification
The bench sweeps every legal sense code over every pin of a four-pin build. For each code it applies a static-low phase, a rising phase, a static-high phase and a falling phase, and predicts each detect vector from the code bits. A decoder with swapped edge polarity, a level mode that fails to latch, or a sense value that leaks onto a neighbouring pin would each set the wrong detect bit. Further checks target the clear-while-active case, where a design that lets the clear win drops the bit, and the three-edge latency, where a missing synchroniser stage reports the event one cycle early. The bench also checks that a write of junk to the upper sense bits, the set-only enable port or an unmapped offset changes nothing that reads back.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int MAX_IN  = 32;
    localparam int SENSE_W = 6;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_REQ   = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_EN    = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_DET   = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_MON   = 10'h104;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 10'h180;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REQ,
        SEL_EN,
        SEL_ENSET,
        SEL_DET,
        SEL_MON,
        SEL_CFG
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [4:0] idx;
    } reg_hit_t;

    typedef struct packed {
        logic lvl;
        logic prev;
    } pin_smp_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a, input int n_in);
        reg_hit_t h;
        h.idx = a[6:2];
        h.sel = SEL_NONE;
        if (a[ADDR_W-1:7] == OFS_CFG[ADDR_W-1:7]) begin
            if (a[1:0] == 2'b00 && int'(a[6:2]) < n_in) h.sel = SEL_CFG;
        end else begin
            case (a)
                OFS_REQ:   h.sel = SEL_REQ;
                OFS_EN:    h.sel = SEL_EN;
                OFS_ENSET: h.sel = SEL_ENSET;
                OFS_DET:   h.sel = SEL_DET;
                OFS_MON:   h.sel = SEL_MON;
                default:   h.sel = SEL_NONE;
            endcase
        end
        return h;
    endfunction

    // sense bits: [0] low level, [1] high level, [2] falling, [3] rising
    function automatic logic sense_hit(input logic [3:0] s, input pin_smp_t p);
        return (s[0] & ~p.lvl) | (s[1] & p.lvl) |
               (s[2] & ~p.lvl & p.prev) | (s[3] & p.lvl & ~p.prev);
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync
    import extint_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_IN-1:0]     pins_i,
    output pin_smp_t [NUM_IN-1:0] smp_o
);
    localparam int DEPTH = 3; // two sync stages plus one history stage

    for (genvar n = 0; n < NUM_IN; n++) begin : g_pin
        logic [DEPTH-1:0] shift_q;
        always_ff @(posedge clk) begin
            if (rst) shift_q <= '0;
            else     shift_q <= {shift_q[DEPTH-2:0], pins_i[n]};
        end
        assign smp_o[n].lvl  = shift_q[1];
        assign smp_o[n].prev = shift_q[2];
    end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  pin_smp_t [NUM_IN-1:0]     smp_i,
    input  logic [NUM_IN*SENSE_W-1:0] cfg_i,
    input  logic [NUM_IN-1:0]         clr_i,
    output logic [NUM_IN-1:0]         det_o
);
    logic [NUM_IN-1:0] hit;

    for (genvar n = 0; n < NUM_IN; n++) begin : g_hit
        assign hit[n] = sense_hit(cfg_i[n*SENSE_W +: 4], smp_i[n]);
    end

    // a new hit outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) det_o <= '0;
        else     det_o <= (det_o & ~clr_i) | hit;
    end
endmodule

// File: rtl/extint_regfile.sv
module extint_regfile
    import extint_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_IN-1:0]         det_i,
    input  logic [NUM_IN-1:0]         lvl_i,
    output logic [NUM_IN*SENSE_W-1:0] cfg_o,
    output logic [NUM_IN-1:0]         en_o,
    output logic [NUM_IN-1:0]         clr_o
);
    reg_hit_t hit;
    logic [NUM_IN-1:0] wmask;

    assign hit   = decode_addr(bus_addr, NUM_IN);
    assign wmask = bus_wdata[NUM_IN-1:0];
    assign clr_o = (bus_we && hit.sel == SEL_DET) ? wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= '0;
        end else if (bus_we) begin
            if (hit.sel == SEL_ENSET) en_o <= en_o | wmask;
            else if (hit.sel == SEL_EN) en_o <= en_o & ~wmask;
        end
    end

    for (genvar n = 0; n < NUM_IN; n++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) cfg_o[n*SENSE_W +: SENSE_W] <= '0;
            else if (bus_we && hit.sel == SEL_CFG && int'(hit.idx) == n)
                cfg_o[n*SENSE_W +: SENSE_W] <= bus_wdata[SENSE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (hit.sel)
            SEL_REQ: bus_rdata[NUM_IN-1:0] = det_i & en_o;
            SEL_EN:  bus_rdata[NUM_IN-1:0] = en_o;
            SEL_DET: bus_rdata[NUM_IN-1:0] = det_i;
            SEL_MON: bus_rdata[NUM_IN-1:0] = lvl_i;
            SEL_CFG: bus_rdata[SENSE_W-1:0] = cfg_o[int'(hit.idx)*SENSE_W +: SENSE_W];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] pins_i,
    output logic [NUM_IN-1:0] irq_o
);
    pin_smp_t [NUM_IN-1:0]     smp;
    logic [NUM_IN-1:0]         lvl_vec;
    logic [NUM_IN-1:0]         det_q;
    logic [NUM_IN-1:0]         en_q;
    logic [NUM_IN-1:0]         clr_mask;
    logic [NUM_IN*SENSE_W-1:0] cfg_flat;

    extint_sync #(.NUM_IN(NUM_IN)) sync_i (
        .clk(clk), .rst(rst), .pins_i(pins_i), .smp_o(smp)
    );

    for (genvar n = 0; n < NUM_IN; n++) begin : g_lvl
        assign lvl_vec[n] = smp[n].lvl;
    end

    extint_detect #(.NUM_IN(NUM_IN)) det_i (
        .clk(clk), .rst(rst), .smp_i(smp), .cfg_i(cfg_flat),
        .clr_i(clr_mask), .det_o(det_q)
    );

    extint_regfile #(.NUM_IN(NUM_IN)) regs_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .det_i(det_q),
        .lvl_i(lvl_vec), .cfg_o(cfg_flat), .en_o(en_q), .clr_o(clr_mask)
    );

    assign irq_o = det_q & en_q;
endmodule

// File: rtl/extint_sense_ctrl_chk.sv
module extint_sense_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic [9:0]                bus_addr,
    input logic [31:0]               bus_wdata,
    input logic [NUM_IN-1:0]         pins_i,
    input logic [NUM_IN-1:0]         lvl_vec,
    input logic [NUM_IN-1:0]         det_q,
    input logic [NUM_IN-1:0]         en_q,
    input logic [NUM_IN*SENSE_W-1:0] cfg_flat
);
    logic [1:0]        since_rst;
    logic [NUM_IN-1:0] bus_clr;
    logic [NUM_IN-1:0] bus_bits;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign bus_bits = bus_wdata[NUM_IN-1:0];
    assign bus_clr  = (bus_we && bus_addr == OFS_DET) ? bus_bits : '0;

    // R2: monitor lags the pins by two edges
    a_r2_sync_depth: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (lvl_vec == $past(pins_i, 2)));

    // R4: a detect bit only drops through a clear write
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        ((det_q & ~bus_clr) != '0) |=> ((($past(det_q) & ~$past(bus_clr)) & ~det_q) == '0));

    // R7: set writes turn the selected enables on
    a_r7_en_set: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_ENSET) |=> ((en_q & $past(bus_bits)) == $past(bus_bits)));

    // R8: clear writes turn the selected enables off
    a_r8_en_clr: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN) |=> ((en_q & $past(bus_bits)) == '0));

    for (genvar n = 0; n < NUM_IN; n++) begin : g_off
        // R6: an empty sense field never raises its bit
        a_r6_sense_off: assert property (@(posedge clk) disable iff (rst)
            (cfg_flat[n*SENSE_W +: SENSE_W] == '0 && !det_q[n]) |=> !det_q[n]);
    end
endmodule

bind extint_sense_ctrl extint_sense_ctrl_chk #(.NUM_IN(NUM_IN)) chk_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pins_i(pins_i), .lvl_vec(lvl_vec),
    .det_q(det_q), .en_q(en_q), .cfg_flat(cfg_flat)
);

// File: tb/extint_sense_ctrl_tb_top.sv
module extint_sense_ctrl_tb_top;
    localparam int N = 4;
    localparam logic [9:0] A_REQ = 10'h000, A_EN = 10'h004, A_ENSET = 10'h008;
    localparam logic [9:0] A_DET = 10'h100, A_MON = 10'h104, A_CFG = 10'h180;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pins = '0;
    logic [N-1:0] irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    extint_sense_ctrl #(.NUM_IN(N)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_i(pins), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic rdchk(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [3:0] mode_of(input int i);
        case (i)
            0: return 4'h0;
            1: return 4'h1;
            2: return 4'h2;
            3: return 4'h4;
            4: return 4'h8;
            default: return 4'hC;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state and unmapped reads
        rdchk("R11 req", A_REQ, 0);
        rdchk("R11 en", A_EN, 0);
        rdchk("R11 det", A_DET, 0);
        rdchk("R11 cfg0", A_CFG, 0);
        rdchk("R11 cfg3", A_CFG + 10'd12, 0);
        rdchk("R11 unmapped", 10'h050, 0);
        rdchk("R11 cfg beyond NUM_IN", A_CFG + 10'd16, 0);
        chk("R11 irq", 32'(irq), 0);

        // R7 R8 R1 enable paths
        wr(A_ENSET, 32'h5);
        rdchk("R8 en read", A_EN, 32'h5);
        rdchk("R7 enset reads 0", A_ENSET, 0);
        wr(A_ENSET, 32'h2);
        rdchk("R7 set keeps others", A_EN, 32'h7);
        wr(A_EN, 32'h1);
        rdchk("R8 clear", A_EN, 32'h6);
        wr(A_ENSET, 32'hFFFF_FFFF);
        rdchk("R1 upper bits 0", A_EN, 32'hF);
        wr(A_EN, 32'hFFFF_FFFF);
        rdchk("R8 clear all", A_EN, 0);
        wr(10'h050, 32'hFFFF_FFFF);
        rdchk("R11 unmapped write", A_EN, 0);

        // sense sweep: every code on every pin, four phases each
        for (int n = 0; n < N; n++) begin
            for (int mi = 0; mi < 6; mi++) begin
                logic [3:0] m;
                logic [31:0] e;
                m = mode_of(mi);
                wr(A_CFG + 10'(4 * n), 32'hFFFF_FFC0 | 32'(m));
                rdchk("R3 cfg readback", A_CFG + 10'(4 * n), 32'(m));
                repeat (3) @(negedge clk);
                wr(A_DET, 32'hF);
                repeat (3) @(negedge clk);
                e = 32'(m[0]) << n;
                rdchk("R4 R6 static low", A_DET, e);
                wr(A_DET, 32'hF);
                pins[n] = 1'b1;
                repeat (4) @(negedge clk);
                e = 32'(m[0] | m[1] | m[3]) << n;
                rdchk("R3 R4 rising phase", A_DET, e);
                chk("R10 masked irq", 32'(irq), 0);
                wr(A_DET, 32'hF);
                repeat (3) @(negedge clk);
                e = 32'(m[1]) << n;
                rdchk("R4 R6 static high", A_DET, e);
                wr(A_DET, 32'hF);
                pins[n] = 1'b0;
                repeat (4) @(negedge clk);
                e = 32'(m[0] | m[1] | m[2]) << n;
                rdchk("R3 R4 falling phase", A_DET, e);
                wr(A_CFG + 10'(4 * n), 0);
                wr(A_DET, 32'hF);
                rdchk("R5 cleared", A_DET, 0);
            end
        end

        // R3 bits 4 and 5 do nothing
        wr(A_CFG, 32'h30);
        pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        pins[0] = 1'b0;
        repeat (4) @(negedge clk);
        rdchk("R3 bits 5:4 inert", A_DET, 0);
        wr(A_CFG, 0);

        // R2 monitor latency
        pins[2] = 1'b1;
        @(negedge clk);
        rdchk("R2 mon after 1 edge", A_MON, 0);
        @(negedge clk);
        rdchk("R2 mon after 2 edges", A_MON, 32'h4);
        pins[2] = 1'b0;
        repeat (3) @(negedge clk);

        // R12 edge latency
        wr(A_CFG, 32'h8);
        pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rdchk("R12 not after 2 edges", A_DET, 0);
        @(negedge clk);
        rdchk("R12 set after 3 edges", A_DET, 32'h1);
        repeat (3) @(negedge clk);
        rdchk("R4 stays after edge", A_DET, 32'h1);
        wr(A_DET, 32'h0);
        rdchk("R5 write 0 no effect", A_DET, 32'h1);
        wr(A_CFG, 0);
        pins[0] = 1'b0;
        wr(A_DET, 32'hF);
        repeat (3) @(negedge clk);

        // R9 R10 R5 level mode, masking and clear-while-active
        for (int n = 0; n < N; n++) wr(A_CFG + 10'(4 * n), 32'h2);
        pins = 4'b0110;
        repeat (4) @(negedge clk);
        rdchk("R4 high level", A_DET, 32'h6);
        wr(A_ENSET, 32'hC);
        rdchk("R9 req", A_REQ, 32'h4);
        chk("R10 irq", 32'(irq), 32'h4);
        wr(A_DET, 32'h2);
        rdchk("R5 active level stays", A_DET, 32'h6);
        pins = 4'b0000;
        repeat (3) @(negedge clk);
        wr(A_DET, 32'h4);
        rdchk("R5 clear when idle", A_DET, 32'h2);
        chk("R10 irq after clear", 32'(irq), 0);
        rdchk("R9 req after clear", A_REQ, 0);
        wr(A_ENSET, 32'h2);
        chk("R10 irq on enable", 32'(irq), 32'h2);
        wr(A_EN, 32'hF);
        chk("R10 irq off on disable", 32'(irq), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule